// File: doc/BRIEF.md
# USB Receive Deserializer

This block sits between a clock-recovery stage and a serial interface engine. It receives an already recovered USB bit stream, one bit per strobe, as a line level and a single-ended-zero flag. It returns parallel words on receive signals of the transceiver-macrocell style.

The block works out the line state on every clock. It hunts for the synchronization pattern and, once the pattern is found, raises an active flag. It decodes the NRZI line coding and removes stuffed zeros. It packs payload bits into bytes, least significant bit first, and presents each completed word with a one-clock valid pulse. Two consecutive single-ended-zero bit times end the packet.

A wide mode pairs bytes into 16-bit words and marks a trailing odd byte. A raw operating mode bypasses the line decoding and bit unstuffing.

Top module: `usb_rx_deser`

## Requirements
- R1: `line_state` is registered from the inputs one clock later and is encoded as follows: 2'b00 when `line_se0` is high, 2'b01 (J) when `line_lvl` is 1, and 2'b10 (K) when `line_lvl` is 0.
- R2: While hunting, a strobed line sequence of J, then K, then K (the tail of the alternating synchronization pattern) raises `rx_active`. No part of that pattern appears as data, and `rx_valid` is only ever high while `rx_active` is high.
- R3: Line decoding produces a 1 when the line level is unchanged from the previous strobed bit and a 0 when it changes. Bytes are assembled least significant bit first. In narrow mode (`wide_mode`=0) each byte appears on `rx_data[7:0]` with the upper byte at zero and `rx_valid_hi` low.
- R4: The run of ones counts the final 1 of the synchronization pattern. After six consecutive decoded 1 bits, a following 0 is discarded and is not counted as data.
- R5: If the bit after six consecutive 1s is a 1, `rx_error` is high for one clock with `rx_valid` low. The partial data is dropped, and `rx_active` is low from the next clock.
- R6: Each completed word gives exactly one single-clock `rx_valid` pulse, and `rx_data` holds that word during the pulse.
- R7: In wide mode (`wide_mode`=1), two bytes form one word: the earlier byte is in `rx_data[7:0]`, the later byte in `rx_data[15:8]`, and `rx_valid_hi` is high.
- R8: In wide mode, a byte left unpaired at the end of the packet is presented with `rx_data[15:8]`=0 and `rx_valid_hi` low.
- R9: The second consecutive strobed single-ended-zero bit ends the packet. Fewer than 8 bits collected since the last byte are discarded. `rx_active` falls one clock after the end is registered, which is one clock after a trailing odd-byte pulse.
- R10: With `op_mode`=2'd2, the line level is taken directly as the data bit and no zeros are removed, so seven or more 1 bits in a row produce no error.
- R11: While `rst` is high, every output is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-clock strobe marking a recovered bit |
| line_lvl | input | 1 | Line level of the bit: 1 = J, 0 = K |
| line_se0 | input | 1 | Bit is a single-ended zero |
| wide_mode | input | 1 | 1 selects 16-bit words |
| op_mode | input | 2 | 2'd2 bypasses line decoding and unstuffing |
| rx_active | output | 1 | Packet in progress |
| rx_valid | output | 1 | Word ready on rx_data this clock |
| rx_error | output | 1 | Bit-stuffing violation detected |
| rx_valid_hi | output | 1 | Upper byte of rx_data is valid |
| rx_data | output | 16 | Received word |
| line_state | output | 2 | Registered line state |

## Verification
If the remembered previous line level is wrong, the next payload word has one bit inverted, and that shows at the first valid pulse after the fault. A ones-run counter that is off by one either raises a false error or lets a stuffed zero into the data, so the word shifts on the first byte of the heavily stuffed patterns. A wrong low-byte latch or pairing flag shows as swapped halves or a wrong `rx_valid_hi` on the next wide word. A wrong end-of-packet handling shows as a lost odd byte or a late fall of `rx_active`, which the cycle-accurate check of the fall catches at once.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int BYTE_BITS = 8;
    localparam int RUN_LIMIT = 6;
    localparam logic [1:0] OPM_RAW = 2'd2;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_RECV  = 2'd1,
        ST_DRAIN = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef struct packed {
        logic stb;
        logic val;
    } bit_ev_t;

    function automatic logic nrzi_bit(input logic cur, input logic prev);
        return ~(cur ^ prev);
    endfunction

    function automatic line_t line_code(input logic se0, input logic lvl);
        if (se0)
            return LS_SE0;
        return lvl ? LS_J : LS_K;
    endfunction

endpackage

// File: rtl/urx_line_front.sv
module urx_line_front
    import urx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_stb,
    input  logic    line_lvl,
    input  logic    line_se0,
    input  logic    bypass,
    output line_t   ls_q,
    output bit_ev_t data_ev,
    output logic    eop_stb,
    output logic    sync_hit
);

    logic prev_q;
    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            hist_q <= 1'b1;
            ls_q   <= LS_SE0;
        end else begin
            ls_q <= line_code(line_se0, line_lvl);
            if (bit_stb) begin
                if (line_se0) begin
                    prev_q <= 1'b1;
                    hist_q <= 1'b1;
                end else begin
                    prev_q <= line_lvl;
                    hist_q <= prev_q;
                end
            end
        end
    end

    always_comb begin
        data_ev.stb = bit_stb && !line_se0;
        data_ev.val = bypass ? line_lvl : nrzi_bit(line_lvl, prev_q);
        eop_stb     = bit_stb && line_se0;
        sync_hit    = data_ev.stb && !line_lvl && !prev_q && hist_q;
    end

    // R1: the encoder never produces the SE1 code
    a_r1_no_se1: assert property (@(posedge clk) disable iff (rst)
        ls_q != LS_SE1);

endmodule

// File: rtl/urx_destuff.sv
module urx_destuff
    import urx_pkg::*;
#(
    parameter int RUN = RUN_LIMIT
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bypass,
    input  logic    restart,
    input  bit_ev_t in_ev,
    output bit_ev_t out_ev,
    output logic    stuff_err
);

    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] run_q;
    logic          at_lim;

    assign at_lim = !bypass && (run_q == CW'(RUN));

    always_comb begin
        out_ev.stb = in_ev.stb && !at_lim;
        out_ev.val = in_ev.val;
        stuff_err  = in_ev.stb && at_lim && in_ev.val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (restart) begin
            run_q <= CW'(1);
        end else if (in_ev.stb) begin
            if (bypass || !in_ev.val)
                run_q <= '0;
            else if (!at_lim)
                run_q <= run_q + CW'(1);
        end
    end

    // R4: the ones run never exceeds the stuffing limit
    a_r4_run_bound: assert property (@(posedge clk) disable iff (rst)
        run_q <= CW'(RUN));

endmodule

// File: rtl/urx_packer.sv
module urx_packer
    import urx_pkg::*;
#(
    parameter int BYTE_W = BYTE_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wide,
    input  logic                  clear,
    input  logic                  flush,
    input  logic                  err_in,
    input  bit_ev_t               in_ev,
    output logic                  valid,
    output logic                  valid_hi,
    output logic                  error,
    output logic [2*BYTE_W-1:0]   data
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] lo_q;
    logic              lo_full_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] byte_next;
    logic              byte_done;

    assign byte_next = {in_ev.val, sh_q[BYTE_W-1:1]};
    assign byte_done = in_ev.stb && (cnt_q == CNT_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            lo_q      <= '0;
            lo_full_q <= 1'b0;
            cnt_q     <= '0;
            valid     <= 1'b0;
            valid_hi  <= 1'b0;
            error     <= 1'b0;
            data      <= '0;
        end else begin
            valid    <= 1'b0;
            valid_hi <= 1'b0;
            error    <= 1'b0;
            if (err_in) begin
                error     <= 1'b1;
                cnt_q     <= '0;
                lo_full_q <= 1'b0;
            end else if (clear) begin
                cnt_q     <= '0;
                lo_full_q <= 1'b0;
            end else if (flush) begin
                if (lo_full_q) begin
                    valid <= 1'b1;
                    data  <= {{BYTE_W{1'b0}}, lo_q};
                end
                cnt_q     <= '0;
                lo_full_q <= 1'b0;
            end else if (in_ev.stb) begin
                sh_q  <= byte_next;
                cnt_q <= byte_done ? '0 : cnt_q + CNT_W'(1);
                if (byte_done) begin
                    if (!wide) begin
                        valid <= 1'b1;
                        data  <= {{BYTE_W{1'b0}}, byte_next};
                    end else if (lo_full_q) begin
                        valid     <= 1'b1;
                        valid_hi  <= 1'b1;
                        data      <= {byte_next, lo_q};
                        lo_full_q <= 1'b0;
                    end else begin
                        lo_q      <= byte_next;
                        lo_full_q <= 1'b1;
                    end
                end
            end
        end
    end

    // R8: the upper-byte flag only accompanies a word
    a_r8_hi_needs_valid: assert property (@(posedge clk) disable iff (rst)
        valid_hi |-> valid);

    // R5: an error pulse carries no word
    a_r5_err_excl: assert property (@(posedge clk) disable iff (rst)
        error |-> !valid);

endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser
    import urx_pkg::*;
#(
    parameter int BYTE_W = BYTE_BITS,
    parameter int RUN    = RUN_LIMIT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_stb,
    input  logic                line_lvl,
    input  logic                line_se0,
    input  logic                wide_mode,
    input  logic [1:0]          op_mode,
    output logic                rx_active,
    output logic                rx_valid,
    output logic                rx_error,
    output logic                rx_valid_hi,
    output logic [2*BYTE_W-1:0] rx_data,
    output logic [1:0]          line_state
);

    rx_state_t state_q;
    line_t     ls_q;
    bit_ev_t   data_ev;
    bit_ev_t   rcv_ev;
    bit_ev_t   keep_ev;
    logic      eop_stb;
    logic      sync_hit;
    logic      stuff_err;
    logic      se0_seen_q;
    logic      bypass;
    logic      recv;
    logic      start;
    logic      flush;

    assign bypass     = (op_mode == OPM_RAW);
    assign recv       = (state_q == ST_RECV);
    assign start      = (state_q == ST_HUNT) && sync_hit;
    assign flush      = recv && eop_stb && se0_seen_q;
    assign rcv_ev     = '{stb: data_ev.stb && recv, val: data_ev.val};
    assign line_state = ls_q;

    urx_line_front u_front (
        .clk      (clk),
        .rst      (rst),
        .bit_stb  (bit_stb),
        .line_lvl (line_lvl),
        .line_se0 (line_se0),
        .bypass   (bypass),
        .ls_q     (ls_q),
        .data_ev  (data_ev),
        .eop_stb  (eop_stb),
        .sync_hit (sync_hit)
    );

    urx_destuff #(.RUN(RUN)) u_destuff (
        .clk       (clk),
        .rst       (rst),
        .bypass    (bypass),
        .restart   (start),
        .in_ev     (rcv_ev),
        .out_ev    (keep_ev),
        .stuff_err (stuff_err)
    );

    urx_packer #(.BYTE_W(BYTE_W)) u_packer (
        .clk      (clk),
        .rst      (rst),
        .wide     (wide_mode),
        .clear    (start),
        .flush    (flush),
        .err_in   (stuff_err),
        .in_ev    (keep_ev),
        .valid    (rx_valid),
        .valid_hi (rx_valid_hi),
        .error    (rx_error),
        .data     (rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HUNT;
            rx_active  <= 1'b0;
            se0_seen_q <= 1'b0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    se0_seen_q <= 1'b0;
                    if (start) begin
                        state_q   <= ST_RECV;
                        rx_active <= 1'b1;
                    end
                end
                ST_RECV: begin
                    if (stuff_err) begin
                        state_q <= ST_DRAIN;
                    end else if (eop_stb) begin
                        if (se0_seen_q)
                            state_q <= ST_DRAIN;
                        else
                            se0_seen_q <= 1'b1;
                    end else if (data_ev.stb) begin
                        se0_seen_q <= 1'b0;
                    end
                end
                ST_DRAIN: begin
                    state_q    <= ST_HUNT;
                    rx_active  <= 1'b0;
                    se0_seen_q <= 1'b0;
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // R2: words only appear inside an active packet
    a_r2_valid_in_active: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_active);

    // R5: an error ends the packet on the next clock
    a_r5_err_ends: assert property (@(posedge clk) disable iff (rst)
        rx_error |=> !rx_active);

    // R6: each word is a single-clock pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9: leaving the packet drops the active flag
    a_r9_drain_drop: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_DRAIN |=> !rx_active);

endmodule

// File: tb/usb_rx_deser_test.sv
`timescale 1ns/1ps
module usb_rx_deser_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_stb = 1'b0;
    logic        line_lvl = 1'b1;
    logic        line_se0 = 1'b0;
    logic        wide_mode = 1'b0;
    logic [1:0]  op_mode = 2'd0;
    logic        rx_active, rx_valid, rx_error, rx_valid_hi;
    logic [15:0] rx_data;
    logic [1:0]  line_state;

    always #4 clk = ~clk;

    usb_rx_deser uut (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .line_lvl(line_lvl),
        .line_se0(line_se0), .wide_mode(wide_mode), .op_mode(op_mode),
        .rx_active(rx_active), .rx_valid(rx_valid), .rx_error(rx_error),
        .rx_valid_hi(rx_valid_hi), .rx_data(rx_data), .line_state(line_state)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // monitor state, driven only here
    logic [15:0] got_d [1024];
    logic        got_h [1024];
    int n_got = 0, n_errp = 0, n_abad = 0, ncyc = 0;
    int last_v_cyc = 0, fall_cyc = 0, err_cyc = 0;
    logic prev_act = 1'b0;

    always @(negedge clk) begin
        ncyc++;
        if (rx_valid) begin
            if (n_got < 1024) begin
                got_d[n_got] = rx_data;
                got_h[n_got] = rx_valid_hi;
            end
            n_got++;
            last_v_cyc = ncyc;
            if (!rx_active) n_abad++;
        end
        if (rx_error) begin
            n_errp++;
            err_cyc = ncyc;
        end
        if (prev_act && !rx_active) fall_cyc = ncyc;
        prev_act = rx_active;
    end

    logic [7:0] pk [16];
    logic enc_lvl;
    int   enc_ones;
    bit   enc_byp;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic sbit(input logic d, input logic s);
        @(negedge clk);
        line_lvl = d;
        line_se0 = s;
        bit_stb  = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic dbit(input logic b);
        if (enc_byp) begin
            enc_lvl = b;
            sbit(b, 1'b0);
        end else if (b) begin
            sbit(enc_lvl, 1'b0);
            enc_ones++;
            if (enc_ones == 6) begin
                enc_lvl = ~enc_lvl;
                sbit(enc_lvl, 1'b0);
                enc_ones = 0;
            end
        end else begin
            enc_lvl = ~enc_lvl;
            enc_ones = 0;
            sbit(enc_lvl, 1'b0);
        end
    endtask

    task automatic send_sync();
        sbit(1'b1, 1'b0);
        sbit(1'b1, 1'b0);
        for (int i = 0; i < 8; i++)
            sbit((i % 2 == 1 && i != 7) ? 1'b1 : 1'b0, 1'b0);
        enc_lvl  = 1'b0;
        enc_ones = 1;
    endtask

    task automatic send_eop();
        sbit(1'b0, 1'b1);
        sbit(1'b0, 1'b1);
        sbit(1'b1, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_pkt(input int n, input bit wide, input bit byp,
                           input int extra, input string tag);
        int base, ebase, abase, nexp;
        logic [15:0] ed [8];
        logic        eh [8];
        wide_mode = wide;
        op_mode   = byp ? 2'd2 : 2'd0;
        enc_byp   = byp;
        base = n_got; ebase = n_errp; abase = n_abad;
        send_sync();
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++)
                dbit(pk[i][k]);
        for (int i = 0; i < extra; i++)
            dbit(1'b0);
        send_eop();
        nexp = 0;
        if (!wide) begin
            for (int i = 0; i < n; i++) begin
                ed[nexp] = {8'h00, pk[i]}; eh[nexp] = 1'b0; nexp++;
            end
        end else begin
            for (int i = 0; i + 1 < n; i += 2) begin
                ed[nexp] = {pk[i+1], pk[i]}; eh[nexp] = 1'b1; nexp++;
            end
            if (n % 2 == 1) begin
                ed[nexp] = {8'h00, pk[n-1]}; eh[nexp] = 1'b0; nexp++;
            end
        end
        chk(n_got - base == nexp, "R6", {tag, " word count"}, n_got - base, nexp);
        if (n_got - base == nexp)
            for (int i = 0; i < nexp; i++) begin
                chk(got_d[base+i] == ed[i], tag, "word data", got_d[base+i], ed[i]);
                chk(got_h[base+i] == eh[i], wide ? "R7" : "R3", "valid_hi",
                    got_h[base+i], eh[i]);
            end
        chk(n_abad == abase, "R2", "valid outside active", n_abad - abase, 0);
        chk(n_errp == ebase, byp ? "R10" : "R5", "unexpected error", n_errp - ebase, 0);
        chk(rx_active == 1'b0, "R9", "active after end", rx_active, 0);
        if (wide && (n % 2 == 1))
            chk(fall_cyc == last_v_cyc + 1, "R8", "active fall after odd byte",
                fall_cyc - last_v_cyc, 1);
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({rx_active, rx_valid, rx_error, rx_valid_hi} == 4'b0, "R11", "flags in reset",
            {rx_active, rx_valid, rx_error, rx_valid_hi}, 0);
        chk(rx_data == 16'h0 && line_state == 2'b00, "R11", "data and line in reset",
            {rx_data, line_state}, 0);
        rst = 1'b0;
        @(negedge clk);
        // R1 line state encoding
        line_lvl = 1'b1; line_se0 = 1'b0; @(negedge clk);
        chk(line_state == 2'b01, "R1", "J code", line_state, 1);
        line_lvl = 1'b0; @(negedge clk);
        chk(line_state == 2'b10, "R1", "K code", line_state, 2);
        line_se0 = 1'b1; @(negedge clk);
        chk(line_state == 2'b00, "R1", "SE0 code", line_state, 0);
        line_se0 = 1'b0; line_lvl = 1'b1; @(negedge clk);
        chk(rx_active == 1'b0, "R2", "no packet from line wiggle", rx_active, 0);

        // directed: R3 narrow mode patterns
        pk[0] = 8'hA5; pk[1] = 8'h00; pk[2] = 8'h3C;
        run_pkt(3, 1'b0, 1'b0, 0, "R3");
        // R4 heavy stuffing
        pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'h7E; pk[3] = 8'hFC;
        run_pkt(4, 1'b0, 1'b0, 0, "R4");
        // R7 wide, even count
        pk[0] = 8'h12; pk[1] = 8'hFE; pk[2] = 8'h80; pk[3] = 8'h01;
        run_pkt(4, 1'b1, 1'b0, 0, "R7");
        // R8 wide, odd trailing byte
        pk[0] = 8'h5A; pk[1] = 8'hC3; pk[2] = 8'h99;
        run_pkt(3, 1'b1, 1'b0, 0, "R8");
        // R9 partial trailing bits dropped
        pk[0] = 8'h44;
        run_pkt(1, 1'b0, 1'b0, 5, "R9");
        // R10 raw mode with long runs of ones
        pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'h0F;
        run_pkt(3, 1'b0, 1'b1, 0, "R10");

        // R5 stuffing violation
        begin
            int base, ebase;
            wide_mode = 1'b0; op_mode = 2'd0; enc_byp = 1'b0;
            base = n_got; ebase = n_errp;
            send_sync();
            for (int i = 0; i < 6; i++) sbit(1'b0, 1'b0);
            send_eop();
            chk(n_errp - ebase == 1, "R5", "error pulses", n_errp - ebase, 1);
            chk(n_got == base, "R5", "words on error", n_got - base, 0);
            chk(fall_cyc == err_cyc + 1, "R5", "active fall after error",
                fall_cyc - err_cyc, 1);
            chk(rx_active == 1'b0, "R5", "active after error", rx_active, 0);
        end

        // constrained random packets
        for (int p = 0; p < 24; p++) begin
            int n;
            bit w, b;
            int ex;
            n  = 1 + int'($urandom % 6);
            w  = bit'($urandom % 2);
            b  = ($urandom % 4) == 0;
            ex = int'($urandom % 8);
            for (int i = 0; i < n; i++) pk[i] = 8'($urandom);
            run_pkt(n, w, b, ex, b ? "R10" : (w ? "R7" : "R3"));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule